// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Register Bank

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of month, month and a two-digit year, plus a weekday number and an optional century flag. A timebase pulse input `tick` arrives `TICK_HZ` times per second. An internal prescaler divides it down to one step per second. The bank also derives a 512 Hz square wave from the prescaler, which can replace bit 0 of the seconds readback for calibration.

A host reaches the bank through a byte-wide register port with a 4-bit offset. Offsets 8 to 15 are decoded and the rest read as zero. The host can freeze what it reads, so a multi-byte read is consistent while the counters keep running. It can also open a write window. Inside the window it stages a new time, which is committed in one cycle when the window closes. The commit also restarts the sub-second prescaler. A stop flag halts timekeeping altogether.

Top module: `tod_rtc_bank`

## Requirements
- R1: After reset the bank reads 00:00:00, weekday 1, day 01, month 01, year 00, with every flag and control bit clear.
- R2: Each group of `TICK_HZ` timebase pulses advances seconds by one in BCD. The units digit wraps from 9 to 0 and carries into the tens digit (09 becomes 10).
- R3: Seconds roll 59 to 00 into minutes, minutes roll 59 to 00 into hours, and hours roll 23 to 00 into the date. At that same step the weekday advances and wraps from 7 to 1.
- R4: The day of month wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends after day 29 when the BCD year is a multiple of four, otherwise after day 28. Month 12 wraps to 01 and advances the year.
- R5: Year 99 wraps to 00. The century bit (weekday byte bit 4) toggles at that wrap only while century tracking (weekday byte bit 5) is set.
- R6: While control bit 6 is set, reads of time registers return a snapshot taken when the bit rose. Counting continues underneath, and clearing the bit shows the live values again.
- R7: Setting control bit 7 opens a write window. Time writes go to a staging copy that reads back while the window is open. Clearing bit 7 loads the staged time into the counters and restarts the prescaler, so the next second ends exactly `TICK_HZ` pulses later.
- R8: Writes to time fields while control bit 7 is clear have no effect on the time.
- R9: While seconds byte bit 7 (stop) is set, neither the time nor the prescaler advances. This flag is writable at any time and reads back in bit 7.
- R10: While weekday byte bit 6 is set, seconds readback bit 0 shows the 512 Hz square, which toggles on every `TICK_HZ/1024` pulses starting from 0 after a prescaler restart. The flag is writable at any time.
- R11: Offsets 0 to 7 read as zero, and writes to them change nothing.
- R12: Register map: 8 control {bit 7 write window, bit 6 freeze}, 9 {stop, seconds[6:0]}, 10 minutes[6:0], 11 hours[5:0], 12 {bit 6 test, bit 5 century enable, bit 4 century, weekday[2:0]}, 13 day[5:0], 14 month[4:0], 15 year[7:0]. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse, `TICK_HZ` per second |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write when set |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
The hardest conditions to reach from the ports are the calendar edges: end of February in leap and non-leap BCD years such as 00, 10 and 24, month ends, and the year wrap with and without century tracking. Reaching them by counting would take simulated years. Each case instead opens the write window, stages 23:59:59 on the target date, and closes the window to restart the prescaler. One second of pulses then lands exactly on the rollover. The same preload makes prescaler phase known, which lets the freeze, stop and test-square checks count pulses exactly.

// File: rtl/tod_pkg.sv
// Package: shared time-of-day record, register offsets and BCD helpers.
// Assumes all calendar fields are packed BCD except the binary weekday.
package tod_pkg;

    localparam logic [3:0] OFS_CTRL = 4'd8;
    localparam logic [3:0] OFS_SEC  = 4'd9;
    localparam logic [3:0] OFS_MIN  = 4'd10;
    localparam logic [3:0] OFS_HOUR = 4'd11;
    localparam logic [3:0] OFS_WDAY = 4'd12;
    localparam logic [3:0] OFS_DAY  = 4'd13;
    localparam logic [3:0] OFS_MON  = 4'd14;
    localparam logic [3:0] OFS_YEAR = 4'd15;

    typedef struct packed {
        logic       cent;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] day;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } tod_t;

    localparam tod_t TOD_RESET = '{cent: 1'b0, year: 8'h00, mon: 5'h01, day: 6'h01,
                                   wday: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};

    // Add one to a two-digit BCD value; units at or above 9 carry.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when the units digit suits the tens parity.
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last day of a BCD month, in BCD.
    function automatic logic [7:0] bcd_last_day(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
// Prescaler: divides the timebase pulse to a once-per-second step and
// exposes a 512 Hz square taken from one of its own count bits.
// Assumes TICK_HZ is a power of two no smaller than 1024.
module tod_prescaler #(
    parameter int unsigned TICK_HZ = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        run,
    input  logic                        restart,
    output logic                        sec_step,
    output logic                        square,
    output logic [$clog2(TICK_HZ)-1:0]  count
);
    localparam int unsigned CNT_W  = $clog2(TICK_HZ);
    localparam int unsigned SQ_BIT = $clog2(TICK_HZ / 1024);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_HZ - 1);

    // Step when the last pulse of a second arrives while running.
    assign sec_step = run && tick && (count == LAST);
    assign square   = count[SQ_BIT];

    // Advance the sub-second count; restart wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (restart)       count <= '0;
        else if (run && tick)   count <= (count == LAST) ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/tod_counter.sv
// Calendar counter: holds the live time and applies one-second steps with
// BCD carries through to the year and century. A load overrides a step.
// Assumes host-written out-of-range values wrap at the next carry point.
module tod_counter
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  tod_t load_val,
    input  logic cent_en,
    output tod_t live
);
    tod_t       nxt;
    logic [7:0] s8, m8, h8, d8, last_day;

    // Compute the time one second later with the full carry chain.
    always_comb begin
        nxt      = live;
        s8       = {1'b0, live.sec};
        m8       = {1'b0, live.min};
        h8       = {2'b0, live.hour};
        d8       = {2'b0, live.day};
        last_day = bcd_last_day(live.mon, live.year);
        if (s8 < 8'h59) nxt.sec = 7'(bcd_inc(s8));
        else begin
            nxt.sec = '0;
            if (m8 < 8'h59) nxt.min = 7'(bcd_inc(m8));
            else begin
                nxt.min = '0;
                if (h8 < 8'h23) nxt.hour = 6'(bcd_inc(h8));
                else begin
                    nxt.hour = '0;
                    nxt.wday = (live.wday >= 3'd7) ? 3'd1 : live.wday + 3'd1;
                    if (d8 < last_day) nxt.day = 6'(bcd_inc(d8));
                    else begin
                        nxt.day = 6'h01;
                        if (live.mon < 5'h12) nxt.mon = 5'(bcd_inc({3'b0, live.mon}));
                        else begin
                            nxt.mon = 5'h01;
                            if (live.year < 8'h99) nxt.year = bcd_inc(live.year);
                            else begin
                                nxt.year = 8'h00;
                                if (cent_en) nxt.cent = ~live.cent;
                            end
                        end
                    end
                end
            end
        end
    end

    // Hold the live time: reset, host commit, or one-second step.
    always_ff @(posedge clk) begin
        if (!rst_n)     live <= TOD_RESET;
        else if (load)  live <= load_val;
        else if (step)  live <= nxt;
    end
endmodule

// File: rtl/tod_hostif.sv
// Host register interface: decodes the byte port, keeps the control and flag
// bits, the staging copy for the write window and the read snapshot, and
// forms the read data. Assumes a write takes effect at the clock edge it is
// presented on and reads are combinational.
module tod_hostif
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_we,
    input  logic [3:0] acc_addr,
    input  logic [7:0] acc_wdata,
    input  tod_t       live,
    input  logic       square,
    output logic [7:0] acc_rdata,
    output logic       commit,
    output tod_t       staged,
    output tod_t       snap,
    output logic       freeze_on,
    output logic       run,
    output logic       cent_en
);
    logic wr_open_q, stop_q, ftest_q;
    logic do_wr, ctrl_wr, open_wr, start_freeze;
    tod_t view;

    assign do_wr        = acc_en && acc_we;
    assign ctrl_wr      = do_wr && (acc_addr == OFS_CTRL);
    assign commit       = ctrl_wr && wr_open_q && !acc_wdata[7];
    assign open_wr      = ctrl_wr && !wr_open_q && acc_wdata[7];
    assign start_freeze = ctrl_wr && !freeze_on && acc_wdata[6];
    assign run          = !stop_q;

    // Control register: write window and freeze request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open_q <= 1'b0;
            freeze_on <= 1'b0;
        end else if (ctrl_wr) begin
            wr_open_q <= acc_wdata[7];
            freeze_on <= acc_wdata[6];
        end
    end

    // Flag bits that take effect on any write, window or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q  <= 1'b0;
            ftest_q <= 1'b0;
            cent_en <= 1'b0;
        end else if (do_wr && acc_addr == OFS_SEC) begin
            stop_q  <= acc_wdata[7];
        end else if (do_wr && acc_addr == OFS_WDAY) begin
            ftest_q <= acc_wdata[6];
            cent_en <= acc_wdata[5];
        end
    end

    // Staging copy: seeded from the live time, edited inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) staged <= TOD_RESET;
        else if (open_wr) staged <= live;
        else if (wr_open_q && do_wr) begin
            case (acc_addr)
                OFS_SEC:  staged.sec  <= acc_wdata[6:0];
                OFS_MIN:  staged.min  <= acc_wdata[6:0];
                OFS_HOUR: staged.hour <= acc_wdata[5:0];
                OFS_WDAY: begin
                    staged.wday <= acc_wdata[2:0];
                    staged.cent <= acc_wdata[4];
                end
                OFS_DAY:  staged.day  <= acc_wdata[5:0];
                OFS_MON:  staged.mon  <= acc_wdata[4:0];
                OFS_YEAR: staged.year <= acc_wdata;
                default:  staged <= staged;
            endcase
        end
    end

    // Read snapshot: captured when the freeze bit rises.
    always_ff @(posedge clk) begin
        if (!rst_n)            snap <= TOD_RESET;
        else if (start_freeze) snap <= live;
    end

    // Pick the visible time: staging in the window, else snapshot, else live.
    always_comb begin
        if (wr_open_q)      view = staged;
        else if (freeze_on) view = snap;
        else                view = live;
    end

    // Read data multiplexer over the decoded offsets.
    always_comb begin
        case (acc_addr)
            OFS_CTRL: acc_rdata = {wr_open_q, freeze_on, 6'b0};
            OFS_SEC:  acc_rdata = {stop_q, view.sec[6:1], ftest_q ? square : view.sec[0]};
            OFS_MIN:  acc_rdata = {1'b0, view.min};
            OFS_HOUR: acc_rdata = {2'b0, view.hour};
            OFS_WDAY: acc_rdata = {1'b0, ftest_q, cent_en, view.cent, 1'b0, view.wday};
            OFS_DAY:  acc_rdata = {2'b0, view.day};
            OFS_MON:  acc_rdata = {3'b0, view.mon};
            OFS_YEAR: acc_rdata = view.year;
            default:  acc_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/tod_rtc_bank.sv
// Top: BCD time-of-day register bank. Wires the prescaler, the calendar
// counter and the host interface. Assumes TICK_HZ is a power of two >= 1024.
module tod_rtc_bank
    import tod_pkg::*;
#(
    parameter int unsigned TICK_HZ = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int unsigned CNT_W = $clog2(TICK_HZ);

    tod_t             live, staged, snap;
    logic             commit, run, cent_en, freeze_on, sec_step, square;
    logic [CNT_W-1:0] pre_count;

    tod_prescaler #(.TICK_HZ(TICK_HZ)) i_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .restart(commit),
        .sec_step(sec_step), .square(square), .count(pre_count)
    );

    tod_counter i_cnt (
        .clk(clk), .rst_n(rst_n), .step(sec_step), .load(commit),
        .load_val(staged), .cent_en(cent_en), .live(live)
    );

    tod_hostif i_host (
        .clk(clk), .rst_n(rst_n), .acc_en(bus_en), .acc_we(bus_we),
        .acc_addr(bus_addr), .acc_wdata(bus_wdata), .live(live), .square(square),
        .acc_rdata(bus_rdata), .commit(commit), .staged(staged), .snap(snap),
        .freeze_on(freeze_on), .run(run), .cent_en(cent_en)
    );
endmodule

// File: rtl/tod_rtc_checker.sv
// Checker: temporal properties across the prescaler, counter and host
// interface of the register bank. Attached by bind below.
module tod_rtc_checker
    import tod_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input tod_t             live,
    input tod_t             staged,
    input tod_t             snap,
    input logic             freeze_on,
    input logic             commit,
    input logic             sec_step,
    input logic             run,
    input logic [CNT_W-1:0] pre_count
);
    // R7: a commit loads exactly the staged time.
    a_r7_commit_loads_staged: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> live == $past(staged));

    // R7: a commit restarts the prescaler.
    a_r7_prescaler_restart: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pre_count == '0);

    // R9: while stopped and no commit, the time holds.
    a_r9_stop_holds_time: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !commit) |=> $stable(live));

    // R6: the snapshot holds while the freeze stays set.
    a_r6_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_on && $past(freeze_on)) |-> $stable(snap));

    // R2: units digit 9 carries into the tens digit.
    a_r2_units_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && !commit && live.sec == 7'h09) |=> live.sec == 7'h10);

    // R3: end of day wraps weekday 7 to 1.
    a_r3_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && !commit && live.sec == 7'h59 && live.min == 7'h59 &&
         live.hour == 6'h23 && live.wday == 3'd7) |=> live.wday == 3'd1);
endmodule

bind tod_rtc_bank tod_rtc_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .live(live), .staged(staged), .snap(snap),
    .freeze_on(freeze_on), .commit(commit), .sec_step(sec_step), .run(run),
    .pre_count(pre_count)
);

// File: tb/test_tod_rtc_bank.sv
// Directed bench for the BCD time-of-day register bank.
module test_tod_rtc_bank;
    localparam int unsigned HZ = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_fail = 0;

    tod_rtc_bank #(.TICK_HZ(HZ)) i_tod_rtc_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        check8(req, $sformatf("offset %0d", a), v, exp);
    endtask

    task automatic pulses(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y);
        wr(4'd8, 8'h80);
        wr(4'd9, s); wr(4'd10, m); wr(4'd11, h); wr(4'd12, wd);
        wr(4'd13, d); wr(4'd14, mo); wr(4'd15, y);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_reset;
        expect_reg("R1", 4'd8, 8'h00);
        expect_reg("R1", 4'd9, 8'h00);
        expect_reg("R1", 4'd10, 8'h00);
        expect_reg("R1", 4'd11, 8'h00);
        expect_reg("R12", 4'd12, 8'h01);
        expect_reg("R12", 4'd13, 8'h01);
        expect_reg("R12", 4'd14, 8'h01);
        expect_reg("R1", 4'd15, 8'h00);
    endtask

    task automatic t_unmapped;
        for (int a = 0; a < 8; a++) wr(4'(a), 8'hFF);
        for (int a = 0; a < 8; a++) expect_reg("R11", 4'(a), 8'h00);
        expect_reg("R11", 4'd9, 8'h00);
        expect_reg("R11", 4'd12, 8'h01);
    endtask

    task automatic t_sec_carry;
        load_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        pulses(HZ - 1);
        expect_reg("R2", 4'd9, 8'h09);
        pulses(1);
        expect_reg("R2", 4'd9, 8'h10);
        pulses(HZ);
        expect_reg("R2", 4'd9, 8'h11);
    endtask

    task automatic t_write_window;
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        pulses(500);
        wr(4'd8, 8'h80);
        wr(4'd10, 8'h45);
        expect_reg("R7", 4'd10, 8'h45);
        expect_reg("R7", 4'd8, 8'h80);
        pulses(700);
        expect_reg("R7", 4'd9, 8'h00);
        wr(4'd8, 8'h00);
        expect_reg("R7", 4'd10, 8'h45);
        pulses(HZ - 1);
        expect_reg("R7", 4'd9, 8'h00);
        pulses(1);
        expect_reg("R7", 4'd9, 8'h01);
    endtask

    task automatic t_ignored;
        wr(4'd9, 8'h30);
        wr(4'd10, 8'h22);
        wr(4'd15, 8'h77);
        expect_reg("R8", 4'd9, 8'h01);
        expect_reg("R8", 4'd10, 8'h45);
        expect_reg("R8", 4'd15, 8'h00);
    endtask

    task automatic t_rollover;
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
        pulses(HZ);
        expect_reg("R3", 4'd9, 8'h00);
        expect_reg("R3", 4'd10, 8'h00);
        expect_reg("R3", 4'd11, 8'h00);
        expect_reg("R3", 4'd12, 8'h01);
        expect_reg("R3", 4'd13, 8'h16);
        expect_reg("R3", 4'd14, 8'h03);
    endtask

    task automatic day_end(input string req, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y, input logic [7:0] ed, input logic [7:0] emo,
                           input logic [7:0] ey);
        load_time(8'h59, 8'h59, 8'h23, 8'h02, d, mo, y);
        pulses(HZ);
        expect_reg(req, 4'd13, ed);
        expect_reg(req, 4'd14, emo);
        expect_reg(req, 4'd15, ey);
    endtask

    task automatic t_months;
        day_end("R4", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21);
        day_end("R4", 8'h30, 8'h09, 8'h21, 8'h01, 8'h10, 8'h21);
        day_end("R4", 8'h30, 8'h01, 8'h21, 8'h31, 8'h01, 8'h21);
        day_end("R4", 8'h31, 8'h01, 8'h21, 8'h01, 8'h02, 8'h21);
        day_end("R4", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
        day_end("R4", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        day_end("R4", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
        day_end("R4", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
        day_end("R4", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
        day_end("R4", 8'h31, 8'h12, 8'h98, 8'h01, 8'h01, 8'h99);
    endtask

    task automatic t_century;
        load_time(8'h59, 8'h59, 8'h23, 8'h23, 8'h31, 8'h12, 8'h99);
        pulses(HZ);
        expect_reg("R5", 4'd15, 8'h00);
        expect_reg("R5", 4'd12, 8'h34);
        load_time(8'h59, 8'h59, 8'h23, 8'h13, 8'h31, 8'h12, 8'h99);
        pulses(HZ);
        expect_reg("R5", 4'd15, 8'h00);
        expect_reg("R5", 4'd12, 8'h14);
    endtask

    task automatic t_freeze;
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(4'd8, 8'h40);
        pulses(2 * HZ);
        expect_reg("R6", 4'd9, 8'h00);
        expect_reg("R6", 4'd8, 8'h40);
        wr(4'd8, 8'h00);
        expect_reg("R6", 4'd9, 8'h02);
    endtask

    task automatic t_stop;
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(4'd9, 8'h80);
        expect_reg("R9", 4'd9, 8'h80);
        pulses(3000);
        expect_reg("R9", 4'd9, 8'h80);
        wr(4'd9, 8'h00);
        pulses(HZ - 1);
        expect_reg("R9", 4'd9, 8'h00);
        pulses(1);
        expect_reg("R9", 4'd9, 8'h01);
    endtask

    task automatic t_ftest;
        load_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(4'd12, 8'h41);
        expect_reg("R10", 4'd12, 8'h41);
        expect_reg("R10", 4'd9, 8'h20);
        pulses(1);
        expect_reg("R10", 4'd9, 8'h21);
        pulses(1);
        expect_reg("R10", 4'd9, 8'h20);
        pulses(1);
        expect_reg("R10", 4'd9, 8'h21);
        wr(4'd12, 8'h01);
        expect_reg("R10", 4'd9, 8'h20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_sec_carry();
        t_write_window();
        t_ignored();
        t_rollover();
        t_months();
        t_century();
        t_freeze();
        t_stop();
        t_ftest();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule